// File: doc/BRIEF.md
# Stuck-At Fault Injection Ripple Adder

This block is a 4-bit ripple-carry adder made of four identical gate-level full-adder cells, wired from the least significant bit upward. The carry into the lowest cell is tied to 0. Each cell has eight signal nodes: its three inputs, three internal gate outputs and two outputs. Any one of these nodes can be forced to a constant 0 or 1. A second, fault-free copy of the same adder runs alongside the faulty one and produces a golden result. A mismatch flag shows whether the injected fault is visible at the outputs for the operands currently applied.

The block supports stuck-at fault coverage studies. A test program picks one fault at a time through the fault index and stuck value ports. It then applies operand patterns and records which patterns raise the mismatch flag. The adder is purely combinational, so it has no states and no transitions. The outputs settle from the inputs through gate logic alone.

Top module: `stuck_fault_adder`

## Requirements
- R1: `gold_sum`/`gold_cout` always equal `op_a + op_b` with a carry-in of 0, taken as a 5-bit result.
- R2: While `flt_en` is 0, `sum` equals `gold_sum`, `cout` equals `gold_cout`, and `mismatch` is 0, for every value of `flt_idx` and `flt_val`.
- R3: `flt_idx[4:3]` selects the cell, where 0 is the least significant bit. `flt_idx[2:0]` selects the node in that cell: 0 = operand a, 1 = operand b, 2 = carry-in, 3 = a XOR b, 4 = a AND b, 5 = (a XOR b) AND carry-in, 6 = sum, 7 = carry-out.
- R4: When `flt_en` is 1, the selected node takes the value of `flt_val` (0 gives stuck-at-0, 1 gives stuck-at-1) in place of its fault-free value. Only that single node is altered.
- R5: A fault on the sum node of cell k forces `sum[k]` to `flt_val`. A fault on the carry-out node of the top cell forces `cout` to `flt_val`.
- R6: A carry-out fault in cell k also drives the carry-in of cell k+1. A carry-in fault in cell k changes only the logic inside cell k.
- R7: `mismatch` is 1 exactly when `{cout,sum}` differs from `{gold_cout,gold_sum}`.
- R8: A fault in cell k never changes sum bits below k.
- R9: Over all 256 operand pairs, 62 of the 64 faults raise `mismatch` at least once. The two that never do are in cell 0: carry-in stuck-at-0 and node 5 stuck-at-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| flt_en | input | 1 | Enables the selected fault |
| flt_idx | input | 5 | Fault site: cell in [4:3], node in [2:0] |
| flt_val | input | 1 | Stuck value (0 or 1) |
| sum | output | 4 | Sum from the faulty adder |
| cout | output | 1 | Carry-out from the faulty adder |
| gold_sum | output | 4 | Fault-free sum |
| gold_cout | output | 1 | Fault-free carry-out |
| mismatch | output | 1 | Faulty result differs from golden |

## Verification
The full 256-pair operand space with faults disabled shows whether the golden adder is correct and whether a disabled fault leaks into the outputs. All-zero operands with single faults on sum, carry-in and carry-out nodes show that each site is decoded correctly. They also show that a carry-out fault reaches the next cell while a carry-in fault stays local. Randomly chosen faults and operands, checked against a bench model of the cell chain, separate correct node decoding from neighbouring-node mix-ups. A sweep of every fault over every operand pair confirms the detected-fault count. It also confirms that the two faults masked by the grounded carry-in are never flagged.

// File: rtl/fault_adder_pkg.sv
package fault_adder_pkg;
    localparam int NODE_W = 3;
    localparam int NODES_PER_CELL = 1 << NODE_W;

    typedef enum logic [NODE_W-1:0] {
        ND_OPA    = 3'd0,
        ND_OPB    = 3'd1,
        ND_CIN    = 3'd2,
        ND_HALF   = 3'd3,
        ND_GEN    = 3'd4,
        ND_PROP   = 3'd5,
        ND_SUM    = 3'd6,
        ND_COUT   = 3'd7
    } node_e;

    function automatic logic site_value(input logic raw, input logic hit,
                                        input logic [NODE_W-1:0] sel,
                                        input node_e id, input logic val);
        return (hit && sel == id) ? val : raw;
    endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import fault_adder_pkg::*;
(
    input  logic              a_i,
    input  logic              b_i,
    input  logic              c_i,
    input  logic              hit_i,
    input  logic [NODE_W-1:0] node_i,
    input  logic              val_i,
    output logic              s_o,
    output logic              c_o
);
    logic na, nb, nc, nh, ng, np;

    always_comb begin
        na  = site_value(a_i, hit_i, node_i, ND_OPA, val_i);
        nb  = site_value(b_i, hit_i, node_i, ND_OPB, val_i);
        nc  = site_value(c_i, hit_i, node_i, ND_CIN, val_i);
        nh  = site_value(na ^ nb, hit_i, node_i, ND_HALF, val_i);
        ng  = site_value(na & nb, hit_i, node_i, ND_GEN, val_i);
        np  = site_value(nh & nc, hit_i, node_i, ND_PROP, val_i);
        s_o = site_value(nh ^ nc, hit_i, node_i, ND_SUM, val_i);
        c_o = site_value(ng | np, hit_i, node_i, ND_COUT, val_i);
    end

    always_comb begin
        if (hit_i && node_i == ND_SUM)
            p_sum_stuck_r5: assert (s_o == val_i);
        if (hit_i && node_i == ND_COUT)
            p_cout_stuck_r5: assert (c_o == val_i);
        if (!hit_i)
            p_cell_clean_r1: assert ({c_o, s_o} == 2'(a_i) + 2'(b_i) + 2'(c_i));
    end
endmodule

// File: rtl/rca_chain.sv
module rca_chain
    import fault_adder_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int CELL_W = 2
) (
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              en_i,
    input  logic [CELL_W-1:0] cell_i,
    input  logic [NODE_W-1:0] node_i,
    input  logic              val_i,
    output logic [WIDTH-1:0]  s_o,
    output logic              c_o
);
    logic [WIDTH:0] carry;
    assign carry[0] = 1'b0;
    assign c_o      = carry[WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic hit;
        assign hit = en_i && (cell_i == CELL_W'(i));
        fa_cell u_cell (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .c_i    (carry[i]),
            .hit_i  (hit),
            .node_i (node_i),
            .val_i  (val_i),
            .s_o    (s_o[i]),
            .c_o    (carry[i+1])
        );
    end
endmodule

// File: rtl/stuck_fault_adder.sv
module stuck_fault_adder
    import fault_adder_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int CELL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int IDX_W  = CELL_W + NODE_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             flt_en,
    input  logic [IDX_W-1:0] flt_idx,
    input  logic             flt_val,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic [WIDTH-1:0] gold_sum,
    output logic             gold_cout,
    output logic             mismatch
);
    logic [CELL_W-1:0] cell_sel;
    logic [NODE_W-1:0] node_sel;
    assign cell_sel = flt_idx[IDX_W-1:NODE_W];
    assign node_sel = flt_idx[NODE_W-1:0];

    rca_chain #(.WIDTH(WIDTH), .CELL_W(CELL_W)) u_faulty (
        .a_i(op_a), .b_i(op_b), .en_i(flt_en), .cell_i(cell_sel),
        .node_i(node_sel), .val_i(flt_val), .s_o(sum), .c_o(cout)
    );

    rca_chain #(.WIDTH(WIDTH), .CELL_W(CELL_W)) u_golden (
        .a_i(op_a), .b_i(op_b), .en_i(1'b0), .cell_i('0),
        .node_i('0), .val_i(1'b0), .s_o(gold_sum), .c_o(gold_cout)
    );

    assign mismatch = (sum != gold_sum) || (cout != gold_cout);

    logic [WIDTH-1:0] low_mask;
    always_comb begin
        for (int k = 0; k < WIDTH; k++)
            low_mask[k] = (k < int'(cell_sel));
    end

    always_comb begin
        p_gold_add_r1: assert ({gold_cout, gold_sum} == (WIDTH+1)'(op_a) + (WIDTH+1)'(op_b));
        if (!flt_en)
            p_clean_r2: assert (sum == gold_sum && cout == gold_cout && !mismatch);
        if (mismatch)
            p_flag_needs_en_r7: assert (flt_en);
        if (flt_en)
            p_lower_bits_r8: assert (((sum ^ gold_sum) & low_mask) == '0);
    end
endmodule

// File: tb/stuck_fault_adder_test.sv
module stuck_fault_adder_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [3:0] op_a, op_b, sum, gold_sum;
    logic       flt_en, flt_val, cout, gold_cout, mismatch;
    logic [4:0] flt_idx;
    int n_checks = 0;
    int n_fail   = 0;

    stuck_fault_adder uut (
        .op_a(op_a), .op_b(op_b), .flt_en(flt_en), .flt_idx(flt_idx),
        .flt_val(flt_val), .sum(sum), .cout(cout), .gold_sum(gold_sum),
        .gold_cout(gold_cout), .mismatch(mismatch)
    );

    function automatic logic frc(logic raw, logic hit, logic [2:0] sel, int id, logic v);
        return (hit && int'(sel) == id) ? v : raw;
    endfunction

    // Bit-level model of the cell chain with one forced node (R3, R4, R6).
    function automatic logic [4:0] model(logic [3:0] a, logic [3:0] b, logic en,
                                         logic [4:0] idx, logic v);
        logic c;
        logic [3:0] s;
        c = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic hit, na, nb, nc, nh, ng, np;
            hit  = en && (int'(idx[4:3]) == k);
            na   = frc(a[k], hit, idx[2:0], 0, v);
            nb   = frc(b[k], hit, idx[2:0], 1, v);
            nc   = frc(c, hit, idx[2:0], 2, v);
            nh   = frc(na ^ nb, hit, idx[2:0], 3, v);
            ng   = frc(na & nb, hit, idx[2:0], 4, v);
            np   = frc(nh & nc, hit, idx[2:0], 5, v);
            s[k] = frc(nh ^ nc, hit, idx[2:0], 6, v);
            c    = frc(ng | np, hit, idx[2:0], 7, v);
        end
        return {c, s};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] a, logic [3:0] b, logic en, logic [4:0] idx, logic v);
        op_a = a; op_b = b; flt_en = en; flt_idx = idx; flt_val = v;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int detected;
        int seed;
        seed = 17;
        void'($urandom(seed));
        @(negedge clk);

        // Idle state: zero operands, fault disabled
        apply(4'd0, 4'd0, 1'b0, 5'd0, 1'b0);
        check({cout, sum, mismatch} == 6'd0, "R2", {cout, sum, mismatch}, 0);

        // R1/R2: exhaustive golden, disabled fault with varying index/value
        for (int v = 0; v < 256; v++) begin
            logic [4:0] exp;
            apply(4'(v >> 4), 4'(v), 1'b0, 5'(v * 7), 1'(v));
            exp = 5'(v >> 4) + 5'(v & 15);
            check({gold_cout, gold_sum} == exp, "R1", {gold_cout, gold_sum}, exp);
            check({cout, sum} == exp && !mismatch, "R2", {mismatch, cout, sum}, exp);
        end

        // Directed R5/R6 cases, operands zero
        apply(4'd0, 4'd0, 1'b1, {2'd2, 3'd6}, 1'b1);
        check({cout, sum} == 5'b00100, "R5 sum node", {cout, sum}, 5'b00100);
        apply(4'd0, 4'd0, 1'b1, {2'd3, 3'd7}, 1'b1);
        check({cout, sum} == 5'b10000, "R5 cout node", {cout, sum}, 5'b10000);
        apply(4'hF, 4'hF, 1'b1, {2'd3, 3'd7}, 1'b0);
        check(cout == 1'b0, "R5 cout s@0", cout, 0);
        apply(4'd0, 4'd0, 1'b1, {2'd1, 3'd7}, 1'b1);
        check({cout, sum} == 5'b00100, "R6 carry chain", {cout, sum}, 5'b00100);
        apply(4'd0, 4'd0, 1'b1, {2'd1, 3'd2}, 1'b1);
        check({cout, sum} == 5'b00010, "R6 cin local", {cout, sum}, 5'b00010);
        check(mismatch == 1'b1, "R7", mismatch, 1);

        // Random faults and operands against the model (R3, R4, R7, R8)
        for (int t = 0; t < 400; t++) begin
            logic [3:0] a, b;
            logic [4:0] idx, exp, gold;
            logic v;
            a = 4'($urandom); b = 4'($urandom); idx = 5'($urandom); v = 1'($urandom);
            apply(a, b, 1'b1, idx, v);
            exp  = model(a, b, 1'b1, idx, v);
            gold = 5'(a) + 5'(b);
            check({cout, sum} == exp, "R3 R4", {cout, sum}, exp);
            check(mismatch == (exp != gold), "R7", mismatch, exp != gold);
        end

        // Full sweep: every fault against every operand pair (R8, R9)
        detected = 0;
        for (int f = 0; f < 64; f++) begin
            bit hit_dut, hit_mod;
            hit_dut = 0; hit_mod = 0;
            for (int v = 0; v < 256; v++) begin
                logic [4:0] exp, gold;
                logic [3:0] lowm;
                apply(4'(v >> 4), 4'(v), 1'b1, 5'(f >> 1), 1'(f));
                exp  = model(4'(v >> 4), 4'(v), 1'b1, 5'(f >> 1), 1'(f));
                gold = 5'(v >> 4) + 5'(v & 15);
                lowm = 4'((1 << (f >> 4)) - 1);
                if (mismatch) hit_dut = 1;
                if (exp != gold) hit_mod = 1;
                check(((sum ^ gold[3:0]) & lowm) == 4'd0, "R8", sum, gold[3:0]);
            end
            check(hit_dut == hit_mod, "R9 per fault", hit_dut, hit_mod);
            if (hit_dut) detected++;
            if (f == 4 || f == 10)
                check(!hit_dut, "R9 masked fault", hit_dut, 0);
        end
        check(detected == 62, "R9 coverage", detected, 62);

        finish_run();
    end
endmodule